// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small processor core with a 13-bit program space. Each cycle the core presents a decoded control code for the instruction at the current address: advance, branch, subroutine entry or exit, or a direct write of the low address byte. The sequencer computes the next address from that code. Branch targets carry only 11 bits, so the two page bits above them come from a separately written page-latch register. That register also supplies all five upper bits when software writes the low byte directly.

Return addresses live in an eight-entry circular stack that is private to the block. No software path reads or writes it. Calls and interrupts share this stack. An interrupt request lets the presented instruction take full effect first. The block then pushes the resulting next address and redirects fetch to the interrupt vector. A return-with-literal also asks the core to load its literal into the working register in the same cycle.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low and after its release, fetch_addr_o is 0x0000 and every stack entry holds 0x0000.
- R2: op_i codes are 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 return-with-literal, 6 return-from-interrupt and 7 low-byte write. Step loads the current address plus one on the next edge, and 0x1FFF wraps to 0x0000.
- R3: Jump loads {page_i[4:3], target_i[10:0]}.
- R4: A low-byte write loads {page_i[4:0], pcl_data_i[7:0]}.
- R5: Call pushes the current address plus one (wrapping) and loads {page_i[4:3], target_i}. Return, return-with-literal and return-from-interrupt each pop the most recently pushed entry into the address.
- R6: The stack holds 8 entries in a ring. A ninth push overwrites the oldest entry. A pop with nothing pushed returns the entry at the position below the pointer and raises no fault.
- R7: With irq_i high, the presented instruction takes its full effect, including its own push or pop. The address that would have followed is then pushed, and the address becomes 0x0004. A call with an interrupt therefore pushes twice.
- R8: w_load_o is high only while op_i is 5, and w_data_o then equals literal_i in that same cycle.
- R9: Hold without an interrupt leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Control code of the instruction at fetch_addr_o |
| irq_i | input | 1 | Take an interrupt after this instruction |
| target_i | input | 11 | Branch target of a jump or call |
| page_i | input | 5 | Page-latch register contents |
| pcl_data_i | input | 8 | Value written to the low address byte |
| literal_i | input | 8 | Literal of a return-with-literal |
| fetch_addr_o | output | 13 | Current fetch address |
| w_load_o | output | 1 | Load the working register this cycle |
| w_data_o | output | 8 | Value for the working register |

## Verification
The bench drives calls nine deep and then pops ten times. A design with a saturating or non-circular pointer would return the wrong addresses once the oldest entry has been overwritten, and again on the pop past empty. It raises interrupts during a call and during a return. A sequencer that skipped the instruction's own stack action, or pushed the pre-instruction address, would come back from the service routine to the wrong place. Fetch is run across 0x1FFF, and jumps and low-byte writes use page values whose unused bits are set. Sign or width slips in the wrap or the page splice would show up there as wrong addresses.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_STEP   = 3'd1,
    OP_JUMP   = 3'd2,
    OP_CALL   = 3'd3,
    OP_RET    = 3'd4,
    OP_RETLW  = 3'd5,
    OP_RETFIE = 3'd6,
    OP_PCL_WR = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pc_ret_stack.sv
// Ring of return addresses; DEPTH must be a power of two.
// Port a = instruction push, port b = interrupt push applied after the instruction.
module pc_ret_stack #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_a_i,
  input  logic [ADDR_W-1:0] push_a_data_i,
  input  logic              push_b_i,
  input  logic [ADDR_W-1:0] push_b_data_i,
  output logic [ADDR_W-1:0] top_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0]     ptr_q, ptr_mid, ptr_d;
  logic [ADDR_W-1:0] mem_q [DEPTH];

  always_comb begin
    ptr_mid = ptr_q;
    if (push_a_i) ptr_mid = ptr_q + 1'b1;
    else if (pop_i) ptr_mid = ptr_q - 1'b1;
    ptr_d = push_b_i ? ptr_mid + 1'b1 : ptr_mid;
  end

  assign top_o = mem_q[ptr_q - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (push_b_i && ptr_mid == PW'(g))       mem_q[g] <= push_b_data_i;
      else if (push_a_i && ptr_q == PW'(g))         mem_q[g] <= push_a_data_i;
    end
  end
endmodule

// File: rtl/pc_next_logic.sv
module pc_next_logic
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]        pc_i,
  input  pc_op_e                   op_i,
  input  logic [JMP_W-1:0]         target_i,
  input  logic [ADDR_W-DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0]        pcl_data_i,
  input  logic [ADDR_W-1:0]        stack_top_i,
  output logic [ADDR_W-1:0]        next_pc_o,
  output logic                     push_o,
  output logic [ADDR_W-1:0]        push_data_o,
  output logic                     pop_o
);
  localparam int PAGE_BITS = ADDR_W - JMP_W;

  logic [ADDR_W-1:0] pc_inc, branch_pc;

  assign pc_inc    = pc_i + 1'b1;
  assign branch_pc = {page_i[ADDR_W-DATA_W-1 -: PAGE_BITS], target_i};
  assign push_data_o = pc_inc;

  always_comb begin
    next_pc_o = pc_i;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    unique case (op_i)
      OP_HOLD:   next_pc_o = pc_i;
      OP_STEP:   next_pc_o = pc_inc;
      OP_JUMP:   next_pc_o = branch_pc;
      OP_CALL: begin
        next_pc_o = branch_pc;
        push_o    = 1'b1;
      end
      OP_RET, OP_RETLW, OP_RETFIE: begin
        next_pc_o = stack_top_i;
        pop_o     = 1'b1;
      end
      OP_PCL_WR: next_pc_o = {page_i, pcl_data_i};
      default:   next_pc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int VECTOR = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               op_i,
  input  logic                     irq_i,
  input  logic [JMP_W-1:0]         target_i,
  input  logic [ADDR_W-DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0]        pcl_data_i,
  input  logic [DATA_W-1:0]        literal_i,
  output logic [ADDR_W-1:0]        fetch_addr_o,
  output logic                     w_load_o,
  output logic [DATA_W-1:0]        w_data_o
);
  pc_op_e            op;
  logic [ADDR_W-1:0] pc_q, pc_d, instr_next, push_data, stack_top;
  logic              push_a, pop;

  assign op = pc_op_e'(op_i);

  pc_next_logic #(.ADDR_W(ADDR_W), .JMP_W(JMP_W), .DATA_W(DATA_W)) i_next (
    .pc_i        (pc_q),
    .op_i        (op),
    .target_i    (target_i),
    .page_i      (page_i),
    .pcl_data_i  (pcl_data_i),
    .stack_top_i (stack_top),
    .next_pc_o   (instr_next),
    .push_o      (push_a),
    .push_data_o (push_data),
    .pop_o       (pop)
  );

  pc_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_stack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pop_i         (pop),
    .push_a_i      (push_a),
    .push_a_data_i (push_data),
    .push_b_i      (irq_i),
    .push_b_data_i (instr_next),
    .top_o         (stack_top)
  );

  assign pc_d = irq_i ? ADDR_W'(VECTOR) : instr_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign w_load_o     = (op == OP_RETLW);
  assign w_data_o     = literal_i;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8,
  parameter int VECTOR = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [2:0]               op_i,
  input logic                     irq_i,
  input logic [JMP_W-1:0]         target_i,
  input logic [ADDR_W-DATA_W-1:0] page_i,
  input logic [DATA_W-1:0]        pcl_data_i,
  input logic [ADDR_W-1:0]        fetch_addr_o
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !irq_i) |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));

  assert_jump_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !irq_i) |=> fetch_addr_o ==
      {$past(page_i[ADDR_W-DATA_W-1 -: ADDR_W-JMP_W]), $past(target_i)});

  assert_pclwr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd7 && !irq_i) |=> fetch_addr_o == {$past(page_i), $past(pcl_data_i)});

  assert_irq_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> fetch_addr_o == ADDR_W'(VECTOR));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && !irq_i) |=> $stable(fetch_addr_o));
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W(ADDR_W), .JMP_W(JMP_W), .DATA_W(DATA_W), .VECTOR(VECTOR)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .irq_i        (irq_i),
  .target_i     (target_i),
  .page_i       (page_i),
  .pcl_data_i   (pcl_data_i),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        irq = 1'b0;
  logic [10:0] tgt = '0;
  logic [4:0]  page = '0;
  logic [7:0]  pcl = '0;
  logic [7:0]  lit = '0;
  logic [12:0] fetch_addr;
  logic        w_load;
  logic [7:0]  w_data;

  int checks = 0;
  int failures = 0;

  int m_pc;
  int m_stk [8];
  int m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .irq_i(irq), .target_i(tgt),
    .page_i(page), .pcl_data_i(pcl), .literal_i(lit),
    .fetch_addr_o(fetch_addr), .w_load_o(w_load), .w_data_o(w_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0;
    m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
  endtask

  task automatic m_push(input int v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  function automatic int m_pop();
    m_sp = (m_sp + 7) % 8;
    return m_stk[m_sp];
  endfunction

  task automatic do_op(input int o, input int t, input int pg, input int pd,
                       input int l, input bit ir, input string req);
    int nx;
    @(negedge clk);
    op = 3'(o); tgt = 11'(t); page = 5'(pg); pcl = 8'(pd); lit = 8'(l); irq = ir;
    #1;
    check("R8", int'(w_load), (o == 5) ? 1 : 0);
    if (o == 5) check("R8", int'(w_data), l & 8'hFF);
    @(posedge clk);
    case (o)
      1: nx = (m_pc + 1) % 8192;
      2: nx = ((pg >> 3) & 3) * 2048 + (t & 11'h7FF);
      3: begin m_push((m_pc + 1) % 8192); nx = ((pg >> 3) & 3) * 2048 + (t & 11'h7FF); end
      4, 5, 6: nx = m_pop();
      7: nx = (pg & 31) * 256 + (pd & 255);
      default: nx = m_pc;
    endcase
    if (ir) begin
      m_push(nx);
      nx = 4;
    end
    m_pc = nx;
    #1;
    check(req, int'(fetch_addr), m_pc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op = 3'd0; irq = 1'b0;
    model_reset();
    #1;
    check("R1", int'(fetch_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", int'(fetch_addr), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    for (int i = 0; i < 3; i++) do_op(1, 0, 0, 0, 0, 0, "R2");
    do_op(0, 0, 0, 0, 0, 0, "R9");
    // page bits 2:0 set to prove they are ignored on jump
    do_op(2, 11'h7FE, 5'b11111, 0, 0, 0, "R3");
    do_op(1, 0, 0, 0, 0, 0, "R2");
    do_op(1, 0, 0, 0, 0, 0, "R2_wrap");
    do_op(7, 0, 5'h0A, 8'h34, 0, 0, "R4");
    do_op(3, 11'h100, 5'b01000, 0, 0, 0, "R5");
    do_op(1, 0, 0, 0, 0, 0, "R2");
    do_op(3, 11'h2AA, 5'b10101, 0, 0, 0, "R5");
    do_op(4, 0, 0, 0, 0, 0, "R5");
    do_op(5, 0, 0, 0, 8'hA5, 0, "R8");
    do_op(3, 11'h055, 5'b00000, 0, 0, 0, "R5");
    do_op(6, 0, 0, 0, 0, 0, "R5");
    do_op(1, 0, 0, 0, 0, 1, "R7_step_irq");
    do_op(1, 0, 0, 0, 0, 0, "R2");
    do_op(6, 0, 0, 0, 0, 0, "R7_return");
    do_op(3, 11'h321, 5'b11000, 0, 0, 1, "R7_call_irq");
    do_op(6, 0, 0, 0, 0, 0, "R7_to_target");
    do_op(4, 0, 0, 0, 0, 0, "R7_after_call");
    do_op(3, 11'h010, 0, 0, 0, 0, "R5");
    do_op(4, 0, 0, 0, 0, 1, "R7_ret_irq");
    do_op(6, 0, 0, 0, 0, 0, "R7");
    do_op(0, 0, 0, 0, 0, 1, "R7_hold_irq");
    do_op(6, 0, 0, 0, 0, 0, "R7");
    do_op(0, 0, 0, 0, 0, 0, "R9");
    do_op(5, 0, 0, 0, 8'h3C, 1, "R8");
    do_op(6, 0, 0, 0, 0, 0, "R7");
    // ring overflow and underflow
    for (int i = 0; i < 9; i++) do_op(3, 11'h040 + i * 16, (i % 4) * 8, 0, 0, 0, "R6_push");
    for (int i = 0; i < 10; i++) do_op(4, 0, 0, 0, 0, 0, "R6_pop");
    do_reset();
    do_op(4, 0, 0, 0, 0, 0, "R1_empty_pop");
    do_op(7, 0, 5'h1F, 8'hFF, 0, 0, "R4");
    do_op(1, 0, 0, 0, 0, 0, "R2_wrap");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule